// File: doc/BRIEF.md
# Multiplexed LED Display Scan Controller

This block drives a common-cathode style multiplexed LED display of up to eight digits. A host writes eight 8-bit digit patterns and a handful of control settings through a simple address, data and write-enable port. The block then lights one digit at a time. It puts that digit's raw pattern on an 8-bit segment bus and pulls the matching line of an active-low digit-select bus. A free-running timer advances through the digits.

Each digit slot is split into sixteen PWM phases, and the intensity setting decides how many of them are lit. A scan-limit setting restricts the scan to the lowest digits. A power control freezes the scan timer and blanks the display while keeping every register writable. A test control lights every segment of every digit, whatever the power setting.

Top module: `led_scan_ctrl`

## Requirements
- R1: After reset the block is in shutdown with test off, all digit, intensity and scan-limit registers read as zero, and the outputs are blank (`seg_o` = 0x00, `dig_n_o` = 0xFF).
- R2: A write to address 0x1..0x8 loads `wr_data` into digit register 0..7 respectively and changes no other digit.
- R3: With scan-limit value n (address 0xB, bits 2:0), digits are visited in the order 0, 1, ..., n, then back to 0. If n is lowered below the active digit, the next advance goes to 0.
- R4: While running, each digit slot lasts 16 × PRESCALE clock cycles (16 PWM phases of PRESCALE cycles each), and the active digit advances at the end of the slot.
- R5: Intensity value v (address 0xA, bits 3:0) lights the active digit during PWM phases 0..v of its slot, which is (v+1) × PRESCALE cycles. The display is blank for the rest of the slot.
- R6: While a digit d is lit, `seg_o` equals digit register d unmodified and `dig_n_o` has only bit d low. Outside test mode at most one select line is ever low.
- R7: Writing 0 to bit 0 of address 0xC enters shutdown: the PWM phase and active digit hold their values, and the outputs are blank. Writing 1 resumes scanning from the held position.
- R8: Register writes made during shutdown are stored and appear on the display once scanning resumes.
- R9: Bit 0 of address 0xF set to 1 forces `seg_o` = 0xFF and `dig_n_o` = 0x00, also during shutdown. Clearing it returns the display to its normal or blank state.
- R10: Writes to addresses 0x0, 0x9, 0xD and 0xE leave every output and every later output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| seg_o | output | 8 | Segment bus, active high |
| dig_n_o | output | 8 | Digit-select bus, active low |

## Verification
The scan assertions assume that the scan-limit register only moves the wrap point, so an active digit above a newly lowered limit is legal until the next slot boundary. The stimulus lowers the limit in the middle of a scan to exercise exactly that case. The output assertions assume that test mode is the only condition that lights more than one digit. The bench therefore enables test only in separate windows and compares the segment and select buses against its behavioural model on every cycle. Writes are driven half a cycle away from the sampling edge, and at most one write is issued per cycle.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 8;

   localparam logic [ADDR_W-1:0] ADDR_NOP       = 4'h0;
   localparam logic [ADDR_W-1:0] ADDR_DIG_FIRST = 4'h1;
   localparam logic [ADDR_W-1:0] ADDR_DIG_LAST  = 4'h8;
   localparam logic [ADDR_W-1:0] ADDR_DECODE    = 4'h9;
   localparam logic [ADDR_W-1:0] ADDR_BRIGHT    = 4'hA;
   localparam logic [ADDR_W-1:0] ADDR_LIMIT     = 4'hB;
   localparam logic [ADDR_W-1:0] ADDR_POWER     = 4'hC;
   localparam logic [ADDR_W-1:0] ADDR_TEST      = 4'hF;
endpackage

// File: rtl/led_scan_regs.sv
module led_scan_regs
   import led_scan_pkg::*;
#(
   parameter int unsigned DIGITS   = 8,
   parameter int unsigned SEG_W    = 8,
   parameter int unsigned PWM_BITS = 4,
   localparam int unsigned IDX_W   = $clog2(DIGITS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [DIGITS-1:0][SEG_W-1:0]  digits_q,
   output logic [PWM_BITS-1:0]           bright_q,
   output logic [IDX_W-1:0]              limit_q,
   output logic                          run_q,
   output logic                          test_q
);
   logic             hit_digit;
   logic [IDX_W-1:0] wr_idx;

   assign hit_digit = (wr_addr >= ADDR_DIG_FIRST) && (wr_addr <= ADDR_DIG_LAST);
   assign wr_idx    = IDX_W'(wr_addr - ADDR_DIG_FIRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digits_q <= '0;
         bright_q <= '0;
         limit_q  <= '0;
         run_q    <= 1'b0;
         test_q   <= 1'b0;
      end else if (wr_en) begin
         if (hit_digit) begin
            digits_q[wr_idx] <= wr_data[SEG_W-1:0];
         end else begin
            unique case (wr_addr)
               ADDR_BRIGHT: bright_q <= wr_data[PWM_BITS-1:0];
               ADDR_LIMIT:  limit_q  <= wr_data[IDX_W-1:0];
               ADDR_POWER:  run_q    <= wr_data[0];
               ADDR_TEST:   test_q   <= wr_data[0];
               default:     ;
            endcase
         end
      end
   end

   AST_SINGLE_DIGIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_digit) |=> ($countones($past(digits_q) ^ digits_q) <= SEG_W)) // R2
      else $error("digit write touched more than one register");
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq #(
   parameter int unsigned DIGITS   = 8,
   parameter int unsigned PWM_BITS = 4,
   parameter int unsigned PRESCALE = 2,
   localparam int unsigned IDX_W   = $clog2(DIGITS),
   localparam int unsigned PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [IDX_W-1:0]    limit,
   output logic [IDX_W-1:0]    idx_q,
   output logic [PWM_BITS-1:0] phase_q
);
   logic step;
   logic slot_end;

   generate
      if (PRESCALE == 1) begin : g_no_pre
         assign step = run;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           pre_q <= '0;
            else if (run && pre_q == PRE_W'(PRESCALE-1)) pre_q <= '0;
            else if (run)                          pre_q <= pre_q + 1'b1;
         end
         assign step = run && (pre_q == PRE_W'(PRESCALE-1));
      end
   endgenerate

   assign slot_end = step && (phase_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         idx_q   <= '0;
      end else if (step) begin
         phase_q <= phase_q + 1'b1;
         if (slot_end) idx_q <= (idx_q >= limit) ? '0 : idx_q + 1'b1;
      end
   end

   AST_SCAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(idx_q) && $stable(phase_q))) // R7
      else $error("scan moved while stopped");
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && idx_q >= limit) |=> (idx_q == '0)) // R3
      else $error("scan did not wrap to digit 0");
   AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && idx_q < limit) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))) // R3
      else $error("scan skipped a digit");
endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive #(
   parameter int unsigned DIGITS   = 8,
   parameter int unsigned SEG_W    = 8,
   parameter int unsigned PWM_BITS = 4,
   localparam int unsigned IDX_W   = $clog2(DIGITS)
) (
   input  logic [DIGITS-1:0][SEG_W-1:0] digits,
   input  logic [IDX_W-1:0]             idx,
   input  logic [PWM_BITS-1:0]          phase,
   input  logic [PWM_BITS-1:0]          bright,
   input  logic                         run,
   input  logic                         test,
   output logic [SEG_W-1:0]             seg,
   output logic [DIGITS-1:0]            dig_n
);
   always_comb begin
      seg   = '0;
      dig_n = '1;
      if (test) begin
         seg   = '1;
         dig_n = '0;
      end else if (run && (phase <= bright)) begin
         seg        = digits[idx];
         dig_n[idx] = 1'b0;
      end
   end
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
   import led_scan_pkg::*;
#(
   parameter int unsigned DIGITS   = 8,
   parameter int unsigned SEG_W    = 8,
   parameter int unsigned PWM_BITS = 4,
   parameter int unsigned PRESCALE = 2,
   localparam int unsigned IDX_W   = $clog2(DIGITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [7:0]        wr_data,
   output logic [SEG_W-1:0]  seg_o,
   output logic [DIGITS-1:0] dig_n_o
);
   generate
      if (DIGITS < 2 || DIGITS > 8 || (1 << IDX_W) != DIGITS) begin : g_bad_digits
         $error("DIGITS must be a power of two from 2 to 8");
      end
      if (SEG_W < 1 || SEG_W > DATA_W) begin : g_bad_seg
         $error("SEG_W must fit the write data width");
      end
      if (PWM_BITS < 1 || PWM_BITS > DATA_W) begin : g_bad_pwm
         $error("PWM_BITS must fit the write data width");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
   endgenerate

   logic [DIGITS-1:0][SEG_W-1:0] digits_q;
   logic [PWM_BITS-1:0]          bright_q;
   logic [IDX_W-1:0]             limit_q;
   logic                         run_q;
   logic                         test_q;
   logic [IDX_W-1:0]             idx_q;
   logic [PWM_BITS-1:0]          phase_q;

   led_scan_regs #(.DIGITS(DIGITS), .SEG_W(SEG_W), .PWM_BITS(PWM_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .digits_q(digits_q), .bright_q(bright_q), .limit_q(limit_q),
      .run_q(run_q), .test_q(test_q)
   );

   led_scan_seq #(.DIGITS(DIGITS), .PWM_BITS(PWM_BITS), .PRESCALE(PRESCALE)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run_q), .limit(limit_q),
      .idx_q(idx_q), .phase_q(phase_q)
   );

   led_scan_drive #(.DIGITS(DIGITS), .SEG_W(SEG_W), .PWM_BITS(PWM_BITS)) u_drive (
      .digits(digits_q), .idx(idx_q), .phase(phase_q), .bright(bright_q),
      .run(run_q), .test(test_q), .seg(seg_o), .dig_n(dig_n_o)
   );

   AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !test_q) |-> (seg_o == '0 && dig_n_o == '1)) // R7
      else $error("display lit during shutdown");
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !test_q |-> ($countones(~dig_n_o) <= 1)) // R6
      else $error("several digit selects active");
   AST_TEST_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      test_q |-> (seg_o == '1 && dig_n_o == '0)) // R9
      else $error("test mode did not light everything");
   AST_DARK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_q && phase_q > bright_q) |-> (dig_n_o == '1)) // R5
      else $error("digit lit outside its PWM window");
endmodule

// File: tb/led_scan_ctrl_tb.sv
module led_scan_ctrl_tb;
   localparam int PRESCALE = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] seg_o;
   logic [7:0] dig_n_o;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   int m_dig[8];
   int m_bright, m_limit, m_pre, m_phase, m_idx;
   bit m_run, m_test;

   always #2.5 clk = ~clk;

   led_scan_ctrl #(.PRESCALE(PRESCALE)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .seg_o(seg_o), .dig_n_o(dig_n_o)
   );

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_dig[i]) m_dig[i] = 0;
         m_bright = 0; m_limit = 0; m_pre = 0; m_phase = 0; m_idx = 0;
         m_run = 0; m_test = 0;
      end else begin
         if (m_run) begin
            m_pre = m_pre + 1;
            if (m_pre == PRESCALE) begin
               m_pre = 0;
               m_phase = m_phase + 1;
               if (m_phase == 16) begin
                  m_phase = 0;
                  m_idx = (m_idx >= m_limit) ? 0 : m_idx + 1;
               end
            end
         end
         if (wr_en) begin
            if (wr_addr >= 1 && wr_addr <= 8) m_dig[wr_addr - 1] = wr_data;
            else if (wr_addr == 4'hA) m_bright = wr_data & 15;
            else if (wr_addr == 4'hB) m_limit = wr_data & 7;
            else if (wr_addr == 4'hC) m_run = wr_data[0];
            else if (wr_addr == 4'hF) m_test = wr_data[0];
         end
      end
   end

   task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      logic [7:0] e_seg, e_dig;
      cycles++;
      if (rst_n && !done) begin
         e_seg = 8'h00; e_dig = 8'hFF;
         if (m_test) begin
            e_seg = 8'hFF; e_dig = 8'h00;
         end else if (m_run && m_phase <= m_bright) begin
            e_seg = 8'(m_dig[m_idx]);
            e_dig = ~(8'(1) << m_idx);
         end
         check(cur_req, seg_o, e_seg, "seg_o");
         check(cur_req, dig_n_o, e_dig, "dig_n_o");
      end
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(3);
      // R1: blank and shut down right after reset
      check("R1", seg_o, 8'h00, "reset seg_o");
      check("R1", dig_n_o, 8'hFF, "reset dig_n_o");
      rst_n = 1'b1;
      idle(4);
      // R8: load digits while still in shutdown
      cur_req = "R8";
      for (int i = 0; i < 8; i++) wr(4'(i + 1), 8'(8'h11 * (i + 1) ^ 8'h5A));
      wr(4'hB, 8'h07);
      wr(4'hA, 8'h0F);
      idle(20);
      // R6/R4: full brightness, all digits scanned
      cur_req = "R6";
      wr(4'hC, 8'h01);
      idle(300);
      // R2: single digit update while scanning
      cur_req = "R2";
      wr(4'h3, 8'hC3);
      idle(120);
      // R5: partial duty cycles
      cur_req = "R5";
      wr(4'hA, 8'h03);
      idle(100);
      wr(4'hA, 8'h00);
      idle(80);
      wr(4'hA, 8'h0F);
      // R3: lower the scan limit mid-scan, then a single digit
      cur_req = "R3";
      wr(4'hB, 8'h02);
      idle(260);
      wr(4'hB, 8'hF8);
      idle(100);
      wr(4'hB, 8'h07);
      idle(60);
      // R10: inert addresses
      cur_req = "R10";
      wr(4'h0, 8'hFF);
      wr(4'h9, 8'hFF);
      wr(4'hD, 8'h00);
      wr(4'hE, 8'h01);
      idle(80);
      // R7: shutdown freezes and blanks, then resume
      cur_req = "R7";
      wr(4'hC, 8'hFE);
      idle(50);
      cur_req = "R8";
      wr(4'h1, 8'h81);
      wr(4'hA, 8'h07);
      idle(10);
      cur_req = "R7";
      wr(4'hC, 8'h01);
      idle(200);
      // R9: test mode overriding shutdown, then running
      cur_req = "R9";
      wr(4'hC, 8'h00);
      wr(4'hF, 8'h01);
      idle(30);
      wr(4'hC, 8'h01);
      idle(40);
      wr(4'hF, 8'h00);
      idle(60);
      // R4: short slot check against an explicit digit change
      cur_req = "R4";
      wr(4'hB, 8'h07);
      idle(100);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule